// File: doc/BRIEF.md
# Configurable Two-Input Array Logic Cell

This block is one tile of a fine-grain two-dimensional logic fabric. A configuration word, loaded through a serial chain, sets the tile's behaviour. The tile picks two operands from its four adjacent tiles (north, east, south, west) or from the horizontal and vertical bus taps that pass it. Each operand can be inverted. The tile then applies one of five functions and places the result on any set of neighbour links and bus taps.

Operand sources are numbered 0 to 3 for north, east, south and west, then `HBUS_N` horizontal taps, then `VBUS_N` vertical taps. With the defaults this gives indices 0..7: 4-5 are horizontal and 6-7 are vertical. A tile on the array border is built with the missing directions switched off. A missing port reads as 0 and must never be used. A legality checker watches the active word. When the word is illegal, it raises an error flag and turns every output enable off.

The configuration word is laid out from the most significant bit down:

- `src_a` (SRC_W bits)
- `src_b` (SRC_W bits)
- `neg_a`
- `neg_b`
- `fn` (3 bits)
- `drive` (one bit per source index, bit i for index i)

Words are shifted in MSB first while `cfg_en` is high. The bit leaving the chain appears on `cfg_so`. The shifted word becomes active only on a `cfg_load` pulse.

Top module: `lac_cell`

## Requirements
- R1: The function code `fn` selects the result: 0 passes operand A, 1 gives the inverse of operand A, 2 gives A AND B, 3 gives A OR B, 4 gives A EXOR B.
- R2: `neg_a` and `neg_b` each invert their own operand before the function is applied, independently of each other.
- R3: Either operand slot may take any legal source index (a neighbour or a bus tap), with no slot tied to a direction.
- R4: Each output port carries the result when its `drive` bit is set and the active word is legal. Otherwise the port is 0, and its enable is 0.
- R5: While `cfg_en` is high the chain shifts one bit per clock, the new bit entering at the least significant end. `cfg_so` shows the bit at the most significant end, so a bit emerges `CFG_W` clocks after it was shifted in. With `cfg_en` low the chain holds.
- R6: Shifting without a load pulse leaves the active word, the output enables and `cfg_err` unchanged.
- R7: A `cfg_load` pulse copies the chain into the active word. The new behaviour is visible from the clock edge that samples the pulse.
- R8: Enabling a drive on a port that is also a selected operand source is illegal. This applies to operand A always, and to operand B when the function uses two inputs.
- R9: A two-input function with both operands taken from bus taps (index 4 or above) is illegal.
- R10: On a border tile, selecting a missing neighbour as a used operand, or enabling a drive towards it, is illegal.
- R11: Function codes 5, 6 and 7 are illegal.
- R12: For the pass and invert functions, operand B is not checked for legality, so its index may equal a driven port.
- R13: After reset, the chain and the active word are all zeros: pass north, no drives. All outputs and enables are 0 and `cfg_so` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_si | input | 1 | Serial configuration data in |
| cfg_load | input | 1 | Copies the chain into the active word |
| cfg_so | output | 1 | Serial configuration data out |
| cfg_err | output | 1 | Active word is illegal |
| nbr_in | input | 4 | Neighbour inputs, bit 0 north, 1 east, 2 south, 3 west |
| hbus_in | input | HBUS_N | Horizontal bus taps |
| vbus_in | input | VBUS_N | Vertical bus taps |
| nbr_out | output | 4 | Neighbour outputs, same bit order |
| nbr_oe | output | 4 | Neighbour output enables |
| hbus_out | output | HBUS_N | Horizontal bus outputs |
| hbus_oe | output | HBUS_N | Horizontal bus enables |
| vbus_out | output | VBUS_N | Vertical bus outputs |
| vbus_oe | output | VBUS_N | Vertical bus enables |

## Verification
The properties assume `cfg_load` is never raised in the same cycle as a shift that is meant to be captured. The bench keeps the two apart: it always drops `cfg_en` for the load cycle. They also assume the data inputs may change freely, while the enables and the error flag depend only on the active word. The bench therefore randomizes every neighbour and bus input on every cycle, including during long shifts. A second tile, built without its south and west neighbours, receives the same serial stream. This exercises the border rules against the same words.

// File: rtl/lac_pkg.sv
package lac_pkg;

   typedef enum logic [2:0] {
      FN_PASS = 3'd0,
      FN_NOT  = 3'd1,
      FN_AND  = 3'd2,
      FN_OR   = 3'd3,
      FN_XOR  = 3'd4
   } lac_fn_e;

   localparam int NBR_N = 4;

   function automatic logic fn_is_dyadic(input logic [2:0] code);
      return (code == FN_AND) || (code == FN_OR) || (code == FN_XOR);
   endfunction

   function automatic logic fn_is_defined(input logic [2:0] code);
      return code <= 3'd4;
   endfunction

endpackage

// File: rtl/lac_cfg_chain.sv
module lac_cfg_chain #(
   parameter int W = 19
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         ser_in,
   input  logic         commit,
   output logic         ser_out,
   output logic [W-1:0] word
);

   logic [W-1:0] chain_q;
   logic [W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else if (shift_en) begin
         chain_q <= {chain_q[W-2:0], ser_in};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (commit) begin
         word_q <= chain_q;
      end
   end

   assign ser_out = chain_q[W-1];
   assign word    = word_q;

endmodule

// File: rtl/lac_opnd_mux.sv
module lac_opnd_mux #(
   parameter int N_SRC = 8,
   parameter int SRC_W = 3
) (
   input  logic [N_SRC-1:0] src,
   input  logic [SRC_W-1:0] sel,
   input  logic             neg,
   output logic             val
);

   logic picked;

   always_comb begin
      picked = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
         if (sel == SRC_W'(i)) picked = src[i];
      end
      val = picked ^ neg;
   end

endmodule

// File: rtl/lac_func_unit.sv
module lac_func_unit
   import lac_pkg::*;
(
   input  logic       op_a,
   input  logic       op_b,
   input  logic [2:0] fn,
   output logic       res
);

   always_comb begin
      unique case (fn)
         FN_PASS: res = op_a;
         FN_NOT:  res = ~op_a;
         FN_AND:  res = op_a & op_b;
         FN_OR:   res = op_a | op_b;
         FN_XOR:  res = op_a ^ op_b;
         default: res = 1'b0;
      endcase
   end

endmodule

// File: rtl/lac_cfg_check.sv
module lac_cfg_check
   import lac_pkg::*;
#(
   parameter int         N_SRC    = 8,
   parameter int         SRC_W    = 3,
   parameter logic [3:0] NBR_MASK = 4'hF
) (
   input  logic [SRC_W-1:0] sel_a,
   input  logic [SRC_W-1:0] sel_b,
   input  logic [2:0]       fn,
   input  logic [N_SRC-1:0] drive,
   output logic             bad
);

   logic ok_a, ok_b, clash_a, clash_b, bus_pair, dead_drive, dyadic;

   always_comb begin
      ok_a    = 1'b0;
      ok_b    = 1'b0;
      clash_a = 1'b0;
      clash_b = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
         if (sel_a == SRC_W'(i)) begin
            ok_a    = (i >= NBR_N) ? 1'b1 : NBR_MASK[i];
            clash_a = drive[i];
         end
         if (sel_b == SRC_W'(i)) begin
            ok_b    = (i >= NBR_N) ? 1'b1 : NBR_MASK[i];
            clash_b = drive[i];
         end
      end
      dyadic     = fn_is_dyadic(fn);
      bus_pair   = (32'(sel_a) >= NBR_N) && (32'(sel_b) >= NBR_N);
      dead_drive = |(drive[NBR_N-1:0] & ~NBR_MASK);
      bad = !fn_is_defined(fn) || !ok_a || clash_a || dead_drive ||
            (dyadic && (!ok_b || clash_b || bus_pair));
   end

endmodule

// File: rtl/lac_cell.sv
module lac_cell
   import lac_pkg::*;
#(
   parameter int HBUS_N = 2,
   parameter int VBUS_N = 2,
   parameter bit HAS_N  = 1'b1,
   parameter bit HAS_E  = 1'b1,
   parameter bit HAS_S  = 1'b1,
   parameter bit HAS_W  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_si,
   input  logic              cfg_load,
   output logic              cfg_so,
   output logic              cfg_err,
   input  logic [3:0]        nbr_in,
   input  logic [HBUS_N-1:0] hbus_in,
   input  logic [VBUS_N-1:0] vbus_in,
   output logic [3:0]        nbr_out,
   output logic [3:0]        nbr_oe,
   output logic [HBUS_N-1:0] hbus_out,
   output logic [HBUS_N-1:0] hbus_oe,
   output logic [VBUS_N-1:0] vbus_out,
   output logic [VBUS_N-1:0] vbus_oe
);

   localparam logic [3:0] NBR_MASK = {HAS_W, HAS_S, HAS_E, HAS_N};
   localparam int N_SRC  = NBR_N + HBUS_N + VBUS_N;
   localparam int SRC_W  = $clog2(N_SRC);
   localparam int CFG_W  = N_SRC + 3 + 2 + 2 * SRC_W;
   localparam int FN_LO  = N_SRC;
   localparam int NEGB_B = N_SRC + 3;
   localparam int NEGA_B = N_SRC + 4;
   localparam int SELB_LO = N_SRC + 5;
   localparam int SELA_LO = N_SRC + 5 + SRC_W;

   if (HBUS_N < 1 || VBUS_N < 1) begin : g_bad_bus
      $error("lac_cell: each bus group needs at least one tap");
   end
   if (!(HAS_N || HAS_E || HAS_S || HAS_W)) begin : g_bad_nbr
      $error("lac_cell: a tile needs at least one neighbour");
   end

   logic [CFG_W-1:0] word;
   logic [N_SRC-1:0] drive;
   logic [2:0]       fn;
   logic [SRC_W-1:0] sel [2];
   logic             neg [2];
   logic             opnd [2];
   logic [N_SRC-1:0] src;
   logic             result;
   logic             bad;
   logic [N_SRC-1:0] oe_all;
   logic [N_SRC-1:0] out_all;

   lac_cfg_chain #(.W(CFG_W)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (cfg_en),
      .ser_in   (cfg_si),
      .commit   (cfg_load),
      .ser_out  (cfg_so),
      .word     (word)
   );

   assign drive  = word[N_SRC-1:0];
   assign fn     = word[FN_LO +: 3];
   assign neg[0] = word[NEGA_B];
   assign neg[1] = word[NEGB_B];
   assign sel[0] = word[SELA_LO +: SRC_W];
   assign sel[1] = word[SELB_LO +: SRC_W];

   assign src = {vbus_in, hbus_in, nbr_in & NBR_MASK};

   for (genvar k = 0; k < 2; k++) begin : g_opnd
      lac_opnd_mux #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_mux (
         .src (src),
         .sel (sel[k]),
         .neg (neg[k]),
         .val (opnd[k])
      );
   end

   lac_func_unit u_fn (
      .op_a (opnd[0]),
      .op_b (opnd[1]),
      .fn   (fn),
      .res  (result)
   );

   lac_cfg_check #(.N_SRC(N_SRC), .SRC_W(SRC_W), .NBR_MASK(NBR_MASK)) u_chk_cfg (
      .sel_a (sel[0]),
      .sel_b (sel[1]),
      .fn    (fn),
      .drive (drive),
      .bad   (bad)
   );

   assign oe_all  = bad ? '0 : drive;
   assign out_all = {N_SRC{result}} & oe_all;

   assign cfg_err  = bad;
   assign nbr_oe   = oe_all[NBR_N-1:0];
   assign nbr_out  = out_all[NBR_N-1:0];
   assign hbus_oe  = oe_all[NBR_N +: HBUS_N];
   assign hbus_out = out_all[NBR_N +: HBUS_N];
   assign vbus_oe  = oe_all[NBR_N + HBUS_N +: VBUS_N];
   assign vbus_out = out_all[NBR_N + HBUS_N +: VBUS_N];

endmodule

// File: rtl/lac_cell_chk.sv
module lac_cell_chk #(
   parameter int N_OUT = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_en,
   input logic             cfg_load,
   input logic             cfg_so,
   input logic             cfg_err,
   input logic [N_OUT-1:0] oe_all,
   input logic [N_OUT-1:0] out_all
);

   // R4
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (oe_all == '0));

   // R4
   undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_all & ~oe_all) == '0);

   // R4
   uniform_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_all & oe_all) == '0) || ((out_all & oe_all) == oe_all));

   // R6
   hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> $stable({cfg_err, oe_all}));

   // R5
   so_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> $stable(cfg_so));

endmodule

bind lac_cell lac_cell_chk #(.N_OUT(N_SRC)) u_prop (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_en   (cfg_en),
   .cfg_load (cfg_load),
   .cfg_so   (cfg_so),
   .cfg_err  (cfg_err),
   .oe_all   ({vbus_oe, hbus_oe, nbr_oe}),
   .out_all  ({vbus_out, hbus_out, nbr_out})
);

// File: tb/sim_lac_cell.sv
module sim_lac_cell;

   localparam int CW = 19;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_en = 1'b0, cfg_si = 1'b0, cfg_load = 1'b0;
   logic [3:0] nbr_in = '0;
   logic [1:0] hbus_in = '0, vbus_in = '0;

   logic so0, err0, so1, err1;
   logic [3:0] no0, ne0, no1, ne1;
   logic [1:0] ho0, he0, vo0, ve0, ho1, he1, vo1, ve1;

   int n_chk = 0;
   int n_err = 0;
   bit chk_on = 1'b0;
   bit done = 1'b0;
   string tag = "R13";

   logic [CW-1:0] m_chain, m_word;

   always #10 clk = ~clk;

   lac_cell u0 (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_si(cfg_si), .cfg_load(cfg_load),
      .cfg_so(so0), .cfg_err(err0), .nbr_in(nbr_in), .hbus_in(hbus_in), .vbus_in(vbus_in),
      .nbr_out(no0), .nbr_oe(ne0), .hbus_out(ho0), .hbus_oe(he0), .vbus_out(vo0), .vbus_oe(ve0)
   );

   lac_cell #(.HAS_S(1'b0), .HAS_W(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_si(cfg_si), .cfg_load(cfg_load),
      .cfg_so(so1), .cfg_err(err1), .nbr_in(nbr_in), .hbus_in(hbus_in), .vbus_in(vbus_in),
      .nbr_out(no1), .nbr_oe(ne1), .hbus_out(ho1), .hbus_oe(he1), .vbus_out(vo1), .vbus_oe(ve1)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_chain <= '0;
         m_word  <= '0;
      end else begin
         if (cfg_en) m_chain <= {m_chain[CW-2:0], cfg_si};
         if (cfg_load) m_word <= m_chain;
      end
   end

   // returns {err, oe[7:0], out[7:0]}
   function automatic logic [16:0] expect_of(input logic [CW-1:0] w, input logic [3:0] has);
      int sa, sb, code;
      logic na, nb, a, b, y, two, err;
      logic [7:0] en, pool, oe;
      sa = int'(w[18:16]);
      sb = int'(w[15:13]);
      na = w[12];
      nb = w[11];
      code = int'(w[10:8]);
      en = w[7:0];
      pool = {vbus_in, hbus_in, nbr_in & has};
      two = (code >= 2) && (code <= 4);
      err = 1'b0;
      if (code > 4) err = 1'b1;
      if (sa < 4 && !has[sa]) err = 1'b1;
      if (en[sa]) err = 1'b1;
      if ((en[3:0] & ~has) != 4'd0) err = 1'b1;
      if (two) begin
         if (sb < 4 && !has[sb]) err = 1'b1;
         if (en[sb]) err = 1'b1;
         if (sa >= 4 && sb >= 4) err = 1'b1;
      end
      a = pool[sa] ^ na;
      b = pool[sb] ^ nb;
      case (code)
         0: y = a;
         1: y = ~a;
         2: y = a & b;
         3: y = a | b;
         4: y = a ^ b;
         default: y = 1'b0;
      endcase
      oe = err ? 8'd0 : en;
      return {err, oe, y ? oe : 8'd0};
   endfunction

   task automatic compare(input string who, input logic [16:0] act, input logic [16:0] exp,
                          input logic so_a, input logic so_e);
      n_chk++;
      if (act !== exp || so_a !== so_e) begin
         n_err++;
         $display("FAIL %s %s: got err/oe/out=%h so=%b, expected %h so=%b",
                  tag, who, act, so_a, exp, so_e);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         compare("u0", {err0, ve0, he0, ne0, vo0, ho0, no0}, expect_of(m_word, 4'b1111),
                 so0, m_chain[CW-1]);
         compare("u1", {err1, ve1, he1, ne1, vo1, ho1, no1}, expect_of(m_word, 4'b0011),
                 so1, m_chain[CW-1]);
      end
   end

   function automatic logic [CW-1:0] mk(input int sa, input int sb, input bit na, input bit nb,
                                        input int code, input logic [7:0] en);
      return {3'(sa), 3'(sb), na, nb, 3'(code), en};
   endfunction

   task automatic jiggle();
      nbr_in  = 4'($urandom);
      hbus_in = 2'($urandom);
      vbus_in = 2'($urandom);
   endtask

   task automatic load_word(input logic [CW-1:0] w);
      tag = "R5/R6 shift";
      for (int i = CW - 1; i >= 0; i--) begin
         @(posedge clk); #1;
         cfg_en = 1'b1;
         cfg_si = w[i];
         jiggle();
      end
      @(posedge clk); #1;
      cfg_en = 1'b0;
      cfg_load = 1'b1;
      @(posedge clk); #1;
      cfg_load = 1'b0;
   endtask

   task automatic run(input string t, input logic [CW-1:0] w, input int cycles);
      load_word(w);
      tag = t;
      for (int i = 0; i < cycles; i++) begin
         jiggle();
         @(posedge clk); #1;
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk_on = 1'b1;
      tag = "R13";
      // R13: reset state, no load yet
      repeat (3) begin jiggle(); @(posedge clk); #1; end
      // R1: each function, drive on hbus0
      run("R1 and",  mk(0, 1, 0, 0, 2, 8'h10), 12);
      run("R1 or",   mk(0, 1, 0, 0, 3, 8'h10), 12);
      run("R1 xor",  mk(0, 1, 0, 0, 4, 8'h10), 12);
      run("R1 pass", mk(1, 0, 0, 0, 0, 8'h20), 12);
      run("R1 not",  mk(1, 0, 0, 0, 1, 8'h20), 12);
      // R2: polarity combinations
      run("R2 nega", mk(0, 1, 1, 0, 2, 8'h40), 10);
      run("R2 negb", mk(0, 1, 0, 1, 3, 8'h40), 10);
      run("R2 both", mk(0, 1, 1, 1, 4, 8'h80), 10);
      // R3: slots from any source; u1 lacks south/west
      run("R3 hbus-south", mk(5, 2, 0, 0, 4, 8'h01), 10);
      run("R3 west-vbus",  mk(3, 7, 0, 0, 2, 8'h02), 10);
      run("R3 east-north", mk(1, 0, 0, 1, 3, 8'hC4), 10);
      // R4: many drives at once
      run("R4 fanout", mk(6, 1, 0, 0, 3, 8'hB5), 12);
      run("R4 fanout2", mk(4, 0, 1, 0, 4, 8'hCA), 12);
      // R8: conflicts on A and B
      run("R8 conflict a", mk(0, 1, 0, 0, 2, 8'h01), 6);
      run("R8 conflict b", mk(0, 1, 0, 0, 3, 8'h12), 6);
      // R9: two buses
      run("R9 bus pair", mk(4, 7, 0, 0, 2, 8'h01), 6);
      // R12: B ignored for single-input functions
      run("R12 pass b bus", mk(4, 7, 0, 0, 0, 8'h01), 6);
      run("R12 not b drv",  mk(0, 1, 0, 0, 1, 8'h12), 6);
      // R10: border rules (u1 missing south and west)
      run("R10 sel west", mk(3, 0, 0, 0, 0, 8'h10), 6);
      run("R10 drv south", mk(0, 1, 0, 0, 2, 8'h04), 6);
      // R11: undefined codes
      run("R11 code5", mk(0, 1, 0, 0, 5, 8'h10), 4);
      run("R11 code7", mk(0, 1, 0, 0, 7, 8'h10), 4);
      // R6: shift a full word with no load; active word must stay
      run("R7 reload", mk(1, 0, 0, 0, 4, 8'h30), 4);
      tag = "R6 no load";
      for (int i = 0; i < CW + 4; i++) begin
         @(posedge clk); #1;
         cfg_en = 1'b1;
         cfg_si = 1'($urandom);
         jiggle();
      end
      @(posedge clk); #1;
      cfg_en = 1'b0;
      // R5: chain holds while cfg_en low
      tag = "R5 hold";
      repeat (6) begin jiggle(); @(posedge clk); #1; end
      // R7: load of the shifted garbage takes effect
      cfg_load = 1'b1;
      tag = "R7 load";
      @(posedge clk); #1;
      cfg_load = 1'b0;
      repeat (6) begin jiggle(); @(posedge clk); #1; end
      @(negedge clk);
      chk_on = 1'b0;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule